// File: doc/BRIEF.md
# Plasma Subfield Drive Sequencer

This block produces the per-frame and per-subfield control timing for the two sustain electrode sides of a plasma panel. A one-cycle frame-start pulse from an idle state starts one frame. The sequencer first runs a single full-write ramp on the Y side. It then runs the number of subfields requested. Each subfield has three phases in a fixed order: addressing, then sustaining, then erasing. After the last erase it pulses a done flag and returns to idle. A new frame-start pulse is needed for the next frame.

In the sustain phase the block emits a number of four-step energy-recovery pulses. The Y side and the X side are driven in opposite polarity. An idle clock with every sustain line low separates each step from the next. The number of pulses in each subfield comes from a packed table of counts. That count is scaled down by a two-bit average-picture-level code, so a brighter picture gets fewer pulses. The subfield count, the count table and the level code are all captured when the frame starts.

Top module: `pdp_subfield_seq`

## Requirements
- R1: A `frame_start` pulse sampled while idle makes `busy` rise at the next clock edge. `y_rampup_en` is then high for exactly FWRITE_LEN cycles, once per frame. A `frame_start` pulse sampled while `busy` is high is ignored.
- R2: Each subfield runs addressing for ADDR_LEN cycles, then its sustain pulses, then erasing for ERASE_LEN cycles, with no gap between phases. The number of subfields is `sf_num`, limited to MAX_SF. With `sf_num` equal to 0 the frame holds only the full-write phase.
- R3: During addressing, only `y_scan_en` and `x_shelf_hi` are high (apart from `busy`).
- R4: Each Y sustain pulse drives `y_er_hi`, `y_sus_hi`, `y_er_lo` and `y_sus_lo` in that order. Each of these steps lasts STEP_LEN cycles.
- R5: In each sustain step the X side shows the opposite polarity. The X steps run `x_er_lo`, `x_sus_lo`, `x_er_hi`, `x_sus_hi`, at the same time as the four Y steps.
- R6: After every sustain step there is exactly one cycle in which all eight sustain and recovery lines are low. No two of the four lines of one side are ever high together.
- R7: During erasing, only `y_rampdn_en` and `x_shelf_neg` are high (apart from `busy`).
- R8: Subfield i takes its count c from bits [i*CNT_W +: CNT_W] of `sus_cnt_flat`, with subfield 0 first. It emits floor(c*(4-L)/4) pulses, where L is `apl_level`: 0 gives the full count, 1 gives 3/4, 2 gives 1/2 and 3 gives 1/4. A result of zero goes straight from addressing to erasing.
- R9: `sf_num`, `sus_cnt_flat` and `apl_level` are captured at frame start. Changes to them during the frame do not alter that frame.
- R10: `frame_done` is high for exactly one cycle, the cycle right after the last erase cycle (or the last full-write cycle when there are no subfields). `busy` is low in that cycle.
- R11: While reset is asserted and right after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle frame start request |
| sf_num | input | $clog2(MAX_SF+1) | Subfields in the frame |
| sus_cnt_flat | input | MAX_SF*CNT_W | Packed sustain counts, subfield 0 in the low bits |
| apl_level | input | 2 | Picture level code that scales the counts |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| x_sus_hi | output | 1 | X sustain high switch |
| x_sus_lo | output | 1 | X sustain low switch |
| x_er_hi | output | 1 | X recovery toward high |
| x_er_lo | output | 1 | X recovery toward low |
| x_shelf_hi | output | 1 | X high shelf during addressing |
| x_shelf_neg | output | 1 | X negative shelf during erasing |
| y_sus_hi | output | 1 | Y sustain high switch |
| y_sus_lo | output | 1 | Y sustain low switch |
| y_er_hi | output | 1 | Y recovery toward high |
| y_er_lo | output | 1 | Y recovery toward low |
| y_scan_en | output | 1 | Y scan enable during addressing |
| y_rampup_en | output | 1 | Y full-write ramp enable |
| y_rampdn_en | output | 1 | Y erase ramp-down enable |

## Verification
Suppose the phase, the step index or the dead-cycle flag holds a wrong value. The wrong state shows up on the drive lines in the same cycle. It appears as a wrong phase line, two lines of one side high at once, or a step with no idle cycle before it, and the cycle-by-cycle scoreboard sees the mismatch at once. A wrong pulse counter, a wrong subfield index or a wrong captured count shows up later. It shows as an erase phase that starts early or late, usually some tens of cycles later, at the end of that subfield's sustain train. A wrong subfield total shows as a misplaced done pulse at the end of the frame.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FWRITE = 3'd1,
        PH_ADDR   = 3'd2,
        PH_SUST   = 3'd3,
        PH_ERASE  = 3'd4
    } seq_phase_e;

    // sustain step index on the Y side; the X side is offset by half a pulse
    localparam logic [1:0] STEP_ER_HI  = 2'd0;
    localparam logic [1:0] STEP_SUS_HI = 2'd1;
    localparam logic [1:0] STEP_ER_LO  = 2'd2;
    localparam logic [1:0] STEP_SUS_LO = 2'd3;

endpackage

// File: rtl/pdp_apl_scale.sv
module pdp_apl_scale #(
    parameter int MAX_SF = 8,
    parameter int CNT_W  = 8,
    localparam int SF_W  = $clog2(MAX_SF + 1)
) (
    input  logic [MAX_SF*CNT_W-1:0] cnt_flat,
    input  logic [SF_W-1:0]         sel,
    input  logic [1:0]              apl,
    output logic [CNT_W-1:0]        pulses
);

    logic [CNT_W-1:0] raw;
    logic [2:0]       mult;
    logic [CNT_W+1:0] prod;

    // pick the count of the current subfield
    always_comb begin
        raw = '0;
        for (int i = 0; i < MAX_SF; i++) begin
            if (sel == SF_W'(i)) begin
                raw = cnt_flat[i*CNT_W +: CNT_W];
            end
        end
    end

    // multiply by 4, 3, 2 or 1 quarters
    assign mult   = 3'd4 - {1'b0, apl};
    assign prod   = {2'b00, raw} * {{(CNT_W - 1){1'b0}}, mult};
    assign pulses = CNT_W'(prod >> 2);

endmodule

// File: rtl/pdp_sus_decode.sv
module pdp_sus_decode #(
    parameter bit MIRROR = 1'b0
) (
    input  logic       active,
    input  logic [1:0] step,
    output logic       er_hi,
    output logic       sus_hi,
    output logic       er_lo,
    output logic       sus_lo
);
    import pdp_seq_pkg::*;

    logic [1:0] eff;
    logic [3:0] hot;

    generate
        if (MIRROR) begin : g_mirror
            // opposite polarity: high half and low half swap
            assign eff = step ^ 2'b10;
        end else begin : g_direct
            assign eff = step;
        end
    endgenerate

    always_comb begin
        hot = '0;
        if (active) begin
            hot[eff] = 1'b1;
        end
    end

    assign er_hi  = hot[STEP_ER_HI];
    assign sus_hi = hot[STEP_SUS_HI];
    assign er_lo  = hot[STEP_ER_LO];
    assign sus_lo = hot[STEP_SUS_LO];

endmodule

// File: rtl/pdp_subfield_seq.sv
module pdp_subfield_seq
    import pdp_seq_pkg::*;
#(
    parameter int MAX_SF     = 8,
    parameter int CNT_W      = 8,
    parameter int FWRITE_LEN = 12,
    parameter int ADDR_LEN   = 10,
    parameter int STEP_LEN   = 3,
    parameter int ERASE_LEN  = 6,
    localparam int SF_W      = $clog2(MAX_SF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic [SF_W-1:0]         sf_num,
    input  logic [MAX_SF*CNT_W-1:0] sus_cnt_flat,
    input  logic [1:0]              apl_level,
    output logic                    busy,
    output logic                    frame_done,
    output logic                    x_sus_hi,
    output logic                    x_sus_lo,
    output logic                    x_er_hi,
    output logic                    x_er_lo,
    output logic                    x_shelf_hi,
    output logic                    x_shelf_neg,
    output logic                    y_sus_hi,
    output logic                    y_sus_lo,
    output logic                    y_er_hi,
    output logic                    y_er_lo,
    output logic                    y_scan_en,
    output logic                    y_rampup_en,
    output logic                    y_rampdn_en
);

    localparam int LONG_A  = (FWRITE_LEN > ADDR_LEN) ? FWRITE_LEN : ADDR_LEN;
    localparam int LONG_B  = (STEP_LEN > ERASE_LEN) ? STEP_LEN : ERASE_LEN;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int TM_W    = $clog2(LONGEST + 1);

    localparam logic [TM_W-1:0] FW_LAST   = TM_W'(FWRITE_LEN - 1);
    localparam logic [TM_W-1:0] AD_LAST   = TM_W'(ADDR_LEN - 1);
    localparam logic [TM_W-1:0] ST_LAST   = TM_W'(STEP_LEN - 1);
    localparam logic [TM_W-1:0] ER_LAST   = TM_W'(ERASE_LEN - 1);
    localparam logic [SF_W-1:0] SF_CAP    = SF_W'(MAX_SF);

    typedef struct packed {
        seq_phase_e               phase;
        logic [TM_W-1:0]          tmr;
        logic [1:0]               step;
        logic                     dead;
        logic [CNT_W-1:0]         pulse;
        logic [SF_W-1:0]          sf;
        logic [SF_W-1:0]          sf_total;
        logic [1:0]               apl;
        logic [MAX_SF*CNT_W-1:0]  cnts;
        logic                     done;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic [CNT_W-1:0] target;
    logic             sus_on;

    // scaled pulse target of the current subfield, from captured values
    pdp_apl_scale #(
        .MAX_SF (MAX_SF),
        .CNT_W  (CNT_W)
    ) u_scale (
        .cnt_flat (st_q.cnts),
        .sel      (st_q.sf),
        .apl      (st_q.apl),
        .pulses   (target)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    st_d.phase    = PH_FWRITE;
                    st_d.tmr      = '0;
                    st_d.sf       = '0;
                    st_d.sf_total = (sf_num > SF_CAP) ? SF_CAP : sf_num;
                    st_d.apl      = apl_level;
                    st_d.cnts     = sus_cnt_flat;
                end
            end
            PH_FWRITE: begin
                if (st_q.tmr == FW_LAST) begin
                    st_d.tmr = '0;
                    if (st_q.sf_total == '0) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_ADDR;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + TM_W'(1);
                end
            end
            PH_ADDR: begin
                if (st_q.tmr == AD_LAST) begin
                    st_d.tmr   = '0;
                    st_d.step  = STEP_ER_HI;
                    st_d.dead  = 1'b0;
                    st_d.pulse = '0;
                    st_d.phase = (target == '0) ? PH_ERASE : PH_SUST;
                end else begin
                    st_d.tmr = st_q.tmr + TM_W'(1);
                end
            end
            PH_SUST: begin
                if (!st_q.dead) begin
                    if (st_q.tmr == ST_LAST) begin
                        st_d.tmr  = '0;
                        st_d.dead = 1'b1;
                    end else begin
                        st_d.tmr = st_q.tmr + TM_W'(1);
                    end
                end else begin
                    st_d.dead = 1'b0;
                    st_d.tmr  = '0;
                    if (st_q.step == STEP_SUS_LO) begin
                        st_d.step = STEP_ER_HI;
                        if ((st_q.pulse + CNT_W'(1)) == target) begin
                            st_d.phase = PH_ERASE;
                        end else begin
                            st_d.pulse = st_q.pulse + CNT_W'(1);
                        end
                    end else begin
                        st_d.step = st_q.step + 2'd1;
                    end
                end
            end
            PH_ERASE: begin
                if (st_q.tmr == ER_LAST) begin
                    st_d.tmr = '0;
                    if ((st_q.sf + SF_W'(1)) == st_q.sf_total) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.sf    = st_q.sf + SF_W'(1);
                        st_d.phase = PH_ADDR;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + TM_W'(1);
                end
            end
            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sus_on = (st_q.phase == PH_SUST) && !st_q.dead;

    pdp_sus_decode #(.MIRROR(1'b0)) u_ydec (
        .active (sus_on),
        .step   (st_q.step),
        .er_hi  (y_er_hi),
        .sus_hi (y_sus_hi),
        .er_lo  (y_er_lo),
        .sus_lo (y_sus_lo)
    );

    pdp_sus_decode #(.MIRROR(1'b1)) u_xdec (
        .active (sus_on),
        .step   (st_q.step),
        .er_hi  (x_er_hi),
        .sus_hi (x_sus_hi),
        .er_lo  (x_er_lo),
        .sus_lo (x_sus_lo)
    );

    assign busy        = (st_q.phase != PH_IDLE);
    assign frame_done  = st_q.done;
    assign y_rampup_en = (st_q.phase == PH_FWRITE);
    assign y_scan_en   = (st_q.phase == PH_ADDR);
    assign x_shelf_hi  = (st_q.phase == PH_ADDR);
    assign y_rampdn_en = (st_q.phase == PH_ERASE);
    assign x_shelf_neg = (st_q.phase == PH_ERASE);

endmodule

// File: rtl/pdp_seq_checker.sv
module pdp_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic busy,
    input logic frame_done,
    input logic x_sus_hi,
    input logic x_sus_lo,
    input logic x_er_hi,
    input logic x_er_lo,
    input logic x_shelf_hi,
    input logic x_shelf_neg,
    input logic y_sus_hi,
    input logic y_sus_lo,
    input logic y_er_hi,
    input logic y_er_lo,
    input logic y_scan_en,
    input logic y_rampup_en,
    input logic y_rampdn_en
);

    logic [3:0] ysus;
    logic [3:0] xsus;
    assign ysus = {y_er_hi, y_sus_hi, y_er_lo, y_sus_lo};
    assign xsus = {x_er_hi, x_sus_hi, x_er_lo, x_sus_lo};

    a_r6_y_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ysus) <= 1);
    a_r6_x_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(xsus) <= 1);
    a_r6_y_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ysus != 4'b0) |=> (ysus == 4'b0) || (ysus == $past(ysus)));
    a_r6_x_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (xsus != 4'b0) |=> (xsus == 4'b0) || (xsus == $past(xsus)));
    a_r5_y_high_x_low: assert property (@(posedge clk) disable iff (!rst_n)
        (y_er_hi || y_sus_hi) |-> (x_er_lo || x_sus_lo));
    a_r5_y_low_x_high: assert property (@(posedge clk) disable iff (!rst_n)
        (y_er_lo || y_sus_lo) |-> (x_er_hi || x_sus_hi));
    a_r4_sus_hi_after_er_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_sus_hi) |-> $past(y_er_hi, 2));
    a_r4_er_lo_after_sus_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_er_lo) |-> $past(y_sus_hi, 2));
    a_r4_sus_lo_after_er_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_sus_lo) |-> $past(y_er_lo, 2));
    a_r1_ramp_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_rampup_en) |-> ($past(frame_start) && !$past(busy)));
    a_r2_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(y_scan_en) |-> (y_er_hi || y_rampdn_en));
    a_r2_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(y_rampdn_en) |-> (y_scan_en || frame_done));
    a_r2_y_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({y_scan_en, y_rampup_en, y_rampdn_en, |ysus}));
    a_r3_r7_x_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({x_shelf_hi, x_shelf_neg, |xsus}));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!busy && $past(y_rampdn_en || y_rampup_en)));

endmodule

bind pdp_subfield_seq pdp_seq_checker u_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .busy        (busy),
    .frame_done  (frame_done),
    .x_sus_hi    (x_sus_hi),
    .x_sus_lo    (x_sus_lo),
    .x_er_hi     (x_er_hi),
    .x_er_lo     (x_er_lo),
    .x_shelf_hi  (x_shelf_hi),
    .x_shelf_neg (x_shelf_neg),
    .y_sus_hi    (y_sus_hi),
    .y_sus_lo    (y_sus_lo),
    .y_er_hi     (y_er_hi),
    .y_er_lo     (y_er_lo),
    .y_scan_en   (y_scan_en),
    .y_rampup_en (y_rampup_en),
    .y_rampdn_en (y_rampdn_en)
);

// File: tb/pdp_subfield_seq_bench.sv
`timescale 1ns/1ps
module pdp_subfield_seq_bench;

    localparam int MAX_SF = 8;
    localparam int CNT_W  = 8;
    localparam int FW     = 12;
    localparam int AD     = 10;
    localparam int ST     = 3;
    localparam int ER     = 6;

    localparam logic [14:0] V_DONE = 15'h4000;
    localparam logic [14:0] V_BUSY = 15'h2000;
    localparam logic [14:0] V_XSH  = 15'h1000;
    localparam logic [14:0] V_XSL  = 15'h0800;
    localparam logic [14:0] V_XEH  = 15'h0400;
    localparam logic [14:0] V_XEL  = 15'h0200;
    localparam logic [14:0] V_XHI  = 15'h0100;
    localparam logic [14:0] V_XNG  = 15'h0080;
    localparam logic [14:0] V_YSH  = 15'h0040;
    localparam logic [14:0] V_YSL  = 15'h0020;
    localparam logic [14:0] V_YEH  = 15'h0010;
    localparam logic [14:0] V_YEL  = 15'h0008;
    localparam logic [14:0] V_YSC  = 15'h0004;
    localparam logic [14:0] V_YRU  = 15'h0002;
    localparam logic [14:0] V_YRD  = 15'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [3:0]  sf_num = '0;
    logic [63:0] cnt_flat = '0;
    logic [1:0]  apl = '0;

    logic busy, frame_done;
    logic x_sus_hi, x_sus_lo, x_er_hi, x_er_lo, x_shelf_hi, x_shelf_neg;
    logic y_sus_hi, y_sus_lo, y_er_hi, y_er_lo, y_scan_en, y_rampup_en, y_rampdn_en;
    logic [14:0] obs;

    int ncmp = 0;
    int nbad = 0;
    logic [14:0] exp_q[$];
    string       tag_q[$];
    logic [14:0] mon_e;
    string       mon_t;

    always #4 clk = ~clk;

    pdp_subfield_seq #(
        .MAX_SF(MAX_SF), .CNT_W(CNT_W), .FWRITE_LEN(FW),
        .ADDR_LEN(AD), .STEP_LEN(ST), .ERASE_LEN(ER)
    ) u_pdp_subfield_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sf_num(sf_num), .sus_cnt_flat(cnt_flat), .apl_level(apl),
        .busy(busy), .frame_done(frame_done),
        .x_sus_hi(x_sus_hi), .x_sus_lo(x_sus_lo), .x_er_hi(x_er_hi),
        .x_er_lo(x_er_lo), .x_shelf_hi(x_shelf_hi), .x_shelf_neg(x_shelf_neg),
        .y_sus_hi(y_sus_hi), .y_sus_lo(y_sus_lo), .y_er_hi(y_er_hi),
        .y_er_lo(y_er_lo), .y_scan_en(y_scan_en), .y_rampup_en(y_rampup_en),
        .y_rampdn_en(y_rampdn_en)
    );

    assign obs = {frame_done, busy, x_sus_hi, x_sus_lo, x_er_hi, x_er_lo,
                  x_shelf_hi, x_shelf_neg, y_sus_hi, y_sus_lo, y_er_hi,
                  y_er_lo, y_scan_en, y_rampup_en, y_rampdn_en};

    task automatic push(input logic [14:0] v, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic check_now(input logic [14:0] e, input string t);
        ncmp++;
        if (obs !== e) begin
            nbad++;
            $display("FAIL %s: got %b expected %b", t, obs, e);
        end
    endtask

    // driver: computes the expected per-cycle outputs from the requirements
    task automatic run_frame(input int nsf, input int lvl, input logic [63:0] cnts,
                             input bit disturb);
        logic [14:0] stepv[4];
        int    eff;
        int    n;
        string pre;
        pre = disturb ? "R9 " : "";
        stepv[0] = V_BUSY | V_YEH | V_XEL;
        stepv[1] = V_BUSY | V_YSH | V_XSL;
        stepv[2] = V_BUSY | V_YEL | V_XEH;
        stepv[3] = V_BUSY | V_YSL | V_XSH;
        @(negedge clk);
        sf_num      = 4'(nsf);
        apl         = 2'(lvl);
        cnt_flat    = cnts;
        frame_start = 1'b1;
        push('0, {pre, "R1 idle in start cycle"}, 1);
        push(V_BUSY | V_YRU, {pre, "R1 full write"}, FW);
        eff = (nsf > MAX_SF) ? MAX_SF : nsf;
        for (int s = 0; s < eff; s++) begin
            n = (int'(cnts[s*CNT_W +: CNT_W]) * (4 - lvl)) / 4;
            push(V_BUSY | V_YSC | V_XHI, {pre, "R2 R3 addressing"}, AD);
            for (int p = 0; p < n; p++) begin
                for (int k = 0; k < 4; k++) begin
                    push(stepv[k], {pre, "R4 R5 R8 sustain step"}, ST);
                    push(V_BUSY, {pre, "R6 dead cycle"}, 1);
                end
            end
            push(V_BUSY | V_YRD | V_XNG, {pre, "R2 R7 R8 erasing"}, ER);
        end
        push(V_DONE, {pre, "R10 done pulse"}, 1);
        push('0, {pre, "R10 back to idle"}, 1);
        @(negedge clk);
        frame_start = 1'b0;
        if (disturb) begin
            repeat (15) @(negedge clk);
            frame_start = 1'b1;
            cnt_flat    = ~cnts;
            apl         = ~apl;
            sf_num      = 4'd1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check_now(mon_e, mon_t);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got hung run expected finished run");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now('0, "R11 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now('0, "R11 outputs after reset");
        // R1 R2 R8: two subfields at full scale
        run_frame(2, 0, 64'h0000_0000_0000_0203, 1'b0);
        // R8: 3/4 scale, middle subfield scales to zero pulses
        run_frame(3, 1, 64'h0000_0000_0008_0104, 1'b0);
        // R8: half scale
        run_frame(2, 2, 64'h0000_0000_0000_0506, 1'b0);
        // R8: quarter scale
        run_frame(1, 3, 64'h0000_0000_0000_0007, 1'b0);
        // R2: no subfields, full write only
        run_frame(0, 0, 64'h0000_0000_0000_0303, 1'b0);
        // R2: subfield request above the limit is clamped to MAX_SF
        run_frame(12, 0, 64'h0101_0101_0101_0101, 1'b0);
        // R9 R1: inputs and a second start change mid-frame
        run_frame(2, 0, 64'h0000_0000_0000_0102, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

endmodule